// File: doc/BRIEF.md
# Lockable Atomic-Update PWM Generator

This block is a single-channel pulse-width modulator with a small word-addressed register interface. A 32-bit counter runs from zero up to the programmed period minus one and then wraps. The registered output shows the active level while the counter is below the duty value and the inactive level for the rest of the period. Period, duty and the two polarity bits are never applied the moment they are written. Writes go to staging copies, and the staged set is copied into the working set at a period boundary.

Software can hold the staged set with a lock bit in the control word. While the lock is set, new period, duty and polarity values only collect in staging, and the waveform keeps its old shape. A control write that clears the lock arms a commit. At the next counter wrap, the period, the duty and the polarity from that write all take effect together, so no period ever mixes old and new settings. The expected programming order is: lock with the current polarity, write period and duty, then unlock with the new polarity. While the channel is disabled, an unlocked commit happens on the next clock, because there is no running period to protect.

Top module: `atomic_pwm`

## Requirements
- R1: After reset, reads of all four registers return 0 and pwm_out is 0.
- R2: Byte offsets are: counter 0x0, period 0x4, duty 0x8, control 0xC. Period and duty read back the last value written. Control keeps only bits 0 (enable), 3 (active level), 4 (idle level), 5 (alignment), 6 (lock) and 8 (low power), and reads 0 in all other bits.
- R3: A read at offset 0x0 returns the live counter value, and a write to offset 0x0 has no effect on the counter.
- R4: While control bit 0 is 0, the counter stays at 0 and pwm_out equals the working idle level.
- R5: While enabled, the counter steps 0, 1, ..., period-1 and then returns to 0. One clock after the counter holds c, pwm_out equals the active level (bit 3) if c < duty, and otherwise equals the idle level (bit 4).
- R6: A working duty of 0 gives a constant idle level. A working duty equal to or greater than the period gives a constant active level. A period of 0 or 1 wraps the counter every cycle.
- R7: When unlocked and enabled, new period and duty values become working values only on the clock edge where the counter wraps.
- R8: While control bit 6 is 1, the working period, duty and polarity do not change, so staged writes leave the waveform unchanged.
- R9: After a control write that clears bit 6, the staged period, the staged duty and the polarity bits of that write become working values together at the next wrap.
- R10: Changes to the polarity bits written while the lock is set wait for the same commit as period and duty.
- R11: Control bits 5 and 8 are stored and read back but do not change the waveform. The output is always left-aligned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wr_en | input | 1 | Register write strobe, sampled on the rising clock edge |
| addr | input | 4 | Register byte offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr, combinational |
| pwm_out | output | 1 | Registered PWM output |

## Verification
A reference model predicts pwm_out cycle by cycle, and a monitor compares it against the design while the bench drives the following patterns. A plain mid-duty wave checks counting and comparison. A duty rewrite in mid-period shows whether the change lands at the wrap or leaks into the current period. Duty values of 0, equal to the period, and above the period check the constant-level ends. A locked sequence that changes period, duty and polarity, followed by an unlock, tells an atomic commit apart from partial or early application. Register reads, writes to the counter offset, setting the alignment and low-power bits, and disabling the channel check the register behaviour and the idle state.

// File: rtl/apwm_pkg.sv
package apwm_pkg;
  localparam int unsigned DW = 32;
  localparam int unsigned AW = 4;
  localparam int unsigned CW = 9;

  localparam logic [AW-1:0] OFS_CNT  = 4'h0;
  localparam logic [AW-1:0] OFS_PER  = 4'h4;
  localparam logic [AW-1:0] OFS_DUTY = 4'h8;
  localparam logic [AW-1:0] OFS_CTRL = 4'hC;

  localparam int unsigned B_EN     = 0;
  localparam int unsigned B_ACTHI  = 3;
  localparam int unsigned B_IDLEHI = 4;
  localparam int unsigned B_ALIGN  = 5;
  localparam int unsigned B_LOCK   = 6;
  localparam int unsigned B_LOWPWR = 8;

  localparam logic [CW-1:0] CTRL_MASK =
    CW'((1 << B_EN) | (1 << B_ACTHI) | (1 << B_IDLEHI) |
        (1 << B_ALIGN) | (1 << B_LOCK) | (1 << B_LOWPWR));

  typedef struct packed {
    logic act_hi;
    logic idle_hi;
  } pol_t;
endpackage

// File: rtl/apwm_counter.sv
module apwm_counter #(
  parameter int unsigned DW = apwm_pkg::DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_i,
  input  logic [DW-1:0] per_i,
  output logic [DW-1:0] cnt_o,
  output logic          wrap_o
);
  logic [DW-1:0] cnt_q, cnt_d;
  logic          last;

  always_comb begin
    last   = (per_i <= DW'(1)) || (cnt_q >= per_i - DW'(1));
    wrap_o = en_i && last;
    if (!en_i || wrap_o) cnt_d = '0;
    else                 cnt_d = cnt_q + DW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  // R4: a disabled channel parks the counter at zero
  p_cnt_park_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> cnt_q == '0);
  // R5: the counter restarts after a wrap and otherwise steps by one
  p_cnt_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_o |=> cnt_q == '0);
  p_cnt_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    en_i && !wrap_o |=> cnt_q == $past(cnt_q) + DW'(1));
endmodule

// File: rtl/apwm_regs.sv
module apwm_regs
  import apwm_pkg::*;
#(
  parameter int unsigned DW = apwm_pkg::DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] cnt_i,
  input  logic          wrap_i,
  output logic [DW-1:0] rdata,
  output logic          en_o,
  output logic [DW-1:0] per_act_o,
  output logic [DW-1:0] duty_act_o,
  output pol_t          pol_act_o
);
  logic [DW-1:0] per_sh_q,  per_sh_d;
  logic [DW-1:0] duty_sh_q, duty_sh_d;
  logic [CW-1:0] ctrl_q,    ctrl_d;
  logic [DW-1:0] per_act_q, per_act_d;
  logic [DW-1:0] duty_act_q, duty_act_d;
  pol_t          pol_act_q, pol_act_d;
  logic          pend_q,    pend_d;
  logic          lock, commit;
  logic          hit_per, hit_duty, hit_ctrl;

  always_comb begin
    hit_per  = wr_en && (addr == OFS_PER);
    hit_duty = wr_en && (addr == OFS_DUTY);
    hit_ctrl = wr_en && (addr == OFS_CTRL);
    en_o     = ctrl_q[B_EN];
    lock     = ctrl_q[B_LOCK];
    commit   = pend_q && !lock && (wrap_i || !en_o);

    per_sh_d   = hit_per  ? wdata : per_sh_q;
    duty_sh_d  = hit_duty ? wdata : duty_sh_q;
    ctrl_d     = hit_ctrl ? (wdata[CW-1:0] & CTRL_MASK) : ctrl_q;

    per_act_d  = per_act_q;
    duty_act_d = duty_act_q;
    pol_act_d  = pol_act_q;
    if (commit) begin
      per_act_d         = per_sh_q;
      duty_act_d        = duty_sh_q;
      pol_act_d.act_hi  = ctrl_q[B_ACTHI];
      pol_act_d.idle_hi = ctrl_q[B_IDLEHI];
    end
    pend_d = (pend_q && !commit) || hit_per || hit_duty || hit_ctrl;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_sh_q   <= '0;
      duty_sh_q  <= '0;
      ctrl_q     <= '0;
      per_act_q  <= '0;
      duty_act_q <= '0;
      pol_act_q  <= '0;
      pend_q     <= 1'b0;
    end else begin
      per_sh_q   <= per_sh_d;
      duty_sh_q  <= duty_sh_d;
      ctrl_q     <= ctrl_d;
      per_act_q  <= per_act_d;
      duty_act_q <= duty_act_d;
      pol_act_q  <= pol_act_d;
      pend_q     <= pend_d;
    end
  end

  always_comb begin
    unique case (addr)
      OFS_CNT:  rdata = cnt_i;
      OFS_PER:  rdata = per_sh_q;
      OFS_DUTY: rdata = duty_sh_q;
      OFS_CTRL: rdata = DW'(ctrl_q);
      default:  rdata = '0;
    endcase
  end

  assign per_act_o  = per_act_q;
  assign duty_act_o = duty_act_q;
  assign pol_act_o  = pol_act_q;

  // R8, R10: a held lock freezes every working setting
  p_lock_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    lock |=> $stable(per_act_q) && $stable(duty_act_q) && $stable(pol_act_q));
  // R7: a running channel changes working values only on a wrap
  p_wrap_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
    en_o && !wrap_i |=> $stable(per_act_q) && $stable(duty_act_q) && $stable(pol_act_q));
endmodule

// File: rtl/apwm_outstage.sv
module apwm_outstage
  import apwm_pkg::*;
#(
  parameter int unsigned DW = apwm_pkg::DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_i,
  input  logic [DW-1:0] cnt_i,
  input  logic [DW-1:0] duty_i,
  input  pol_t          pol_i,
  output logic          pwm_o
);
  logic pwm_q, pwm_d;

  always_comb begin
    if (!en_i)                pwm_d = pol_i.idle_hi;
    else if (cnt_i < duty_i)  pwm_d = pol_i.act_hi;
    else                      pwm_d = pol_i.idle_hi;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pwm_q <= 1'b0;
    else        pwm_q <= pwm_d;
  end

  assign pwm_o = pwm_q;

  // R4: a disabled channel shows the idle level
  p_idle_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> pwm_o == $past(pol_i.idle_hi));
  // R6: zero duty never shows the active level
  p_duty_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    en_i && duty_i == '0 |=> pwm_o == $past(pol_i.idle_hi));
endmodule

// File: rtl/atomic_pwm.sv
module atomic_pwm
  import apwm_pkg::*;
#(
  parameter int unsigned DW          = apwm_pkg::DW,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          pwm_out
);
  logic [SYNC_STAGES-1:0] rs_q;
  logic                   rst_sync_n;
  logic                   en;
  logic                   wrap;
  logic [DW-1:0]          cnt, per_act, duty_act;
  pol_t                   pol_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_sync_n = rs_q[SYNC_STAGES-1];

  apwm_regs #(.DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .cnt_i(cnt), .wrap_i(wrap), .rdata(rdata), .en_o(en),
    .per_act_o(per_act), .duty_act_o(duty_act), .pol_act_o(pol_act)
  );

  apwm_counter #(.DW(DW)) u_cnt (
    .clk(clk), .rst_n(rst_sync_n), .en_i(en), .per_i(per_act),
    .cnt_o(cnt), .wrap_o(wrap)
  );

  apwm_outstage #(.DW(DW)) u_out (
    .clk(clk), .rst_n(rst_sync_n), .en_i(en), .cnt_i(cnt),
    .duty_i(duty_act), .pol_i(pol_act), .pwm_o(pwm_out)
  );
endmodule

// File: tb/tb_atomic_pwm.sv
module tb_atomic_pwm;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  addr = 4'h0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        pwm_out;

  int n_cmp = 0;
  int n_bad = 0;
  bit chk_on = 1'b0;
  bit done = 1'b0;
  string phase = "R1";

  typedef struct { bit exp; string tag; } item_t;
  item_t sb_q[$];

  // model state
  logic [31:0] m_cnt = '0, m_per = '0, m_duty = '0, m_psh = '0, m_dsh = '0, m_ctrl = '0;
  bit m_acthi = 0, m_idlehi = 0, m_pend = 0;

  atomic_pwm dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
                  .wdata(wdata), .rdata(rdata), .pwm_out(pwm_out));

  always #5 clk = ~clk;

  always @(posedge clk) begin
    bit en, lock, wrap, commit, nxt;
    en     = m_ctrl[0];
    lock   = m_ctrl[6];
    nxt    = en ? ((m_cnt < m_duty) ? m_acthi : m_idlehi) : m_idlehi;
    wrap   = en && ((m_per <= 1) || (m_cnt >= m_per - 1));
    commit = m_pend && !lock && (wrap || !en);
    if (chk_on) sb_q.push_back('{nxt, phase});
    m_cnt = (!en || wrap) ? 32'd0 : m_cnt + 1;
    if (commit) begin
      m_per = m_psh; m_duty = m_dsh; m_acthi = m_ctrl[3]; m_idlehi = m_ctrl[4];
      m_pend = 0;
    end
    if (wr_en) begin
      case (addr)
        4'h4: begin m_psh = wdata; m_pend = 1; end
        4'h8: begin m_dsh = wdata; m_pend = 1; end
        4'hC: begin m_ctrl = wdata & 32'h179; m_pend = 1; end
        default: ;
      endcase
    end
  end

  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      n_cmp++;
      if (pwm_out !== it.exp) begin
        n_bad++;
        $display("FAIL %s pwm_out actual %0b expected %0b at %0t", it.tag, pwm_out, it.exp, $time);
      end
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(input logic [3:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    addr = a;
    #1;
    n_cmp++;
    if (rdata !== exp) begin
      n_bad++;
      $display("FAIL %s read 0x%0h actual 0x%0h expected 0x%0h", tag, a, rdata, exp);
    end
  endtask

  task automatic rd_cnt(input string tag);
    @(negedge clk);
    addr = 4'h0;
    #1;
    n_cmp++;
    if (rdata !== m_cnt) begin
      n_bad++;
      $display("FAIL %s counter actual %0d expected %0d", tag, rdata, m_cnt);
    end
  endtask

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1: reset state
    rd_chk(4'h0, 32'h0, "R1"); rd_chk(4'h4, 32'h0, "R1");
    rd_chk(4'h8, 32'h0, "R1"); rd_chk(4'hC, 32'h0, "R1");
    n_cmp++;
    if (pwm_out !== 1'b0) begin n_bad++; $display("FAIL R1 pwm_out actual %0b expected 0", pwm_out); end
    chk_on = 1'b1;

    // R2: control keeps only implemented bits
    phase = "R2";
    wr(4'hC, 32'hFFFF_FEFE);
    rd_chk(4'hC, 32'h0000_0078, "R2");
    wr(4'hC, 32'h0);
    rd_chk(4'hC, 32'h0, "R2");

    // R5: plain wave, period 10 duty 3, active high idle low
    phase = "R5";
    wr(4'h4, 32'd10); wr(4'h8, 32'd3);
    rd_chk(4'h4, 32'd10, "R2"); rd_chk(4'h8, 32'd3, "R2");
    wr(4'hC, 32'h9);
    run(40);

    // R3: live counter read, writes ignored
    rd_cnt("R3"); run(3); rd_cnt("R3");
    wr(4'h0, 32'd5); rd_cnt("R3"); run(2); rd_cnt("R3");

    // R7: mid-period duty change lands at wrap
    phase = "R7";
    run(4);
    wr(4'h8, 32'd7);
    run(30);

    // R6: constant ends
    phase = "R6";
    wr(4'h8, 32'd0);  run(25);
    wr(4'h8, 32'd10); run(25);
    wr(4'h8, 32'd12); run(25);
    wr(4'h4, 32'd1);  run(10);
    wr(4'h4, 32'd10); wr(4'h8, 32'd4); run(25);

    // R8: locked staging with old polarity
    phase = "R8";
    wr(4'hC, 32'h49);
    wr(4'h4, 32'd6); wr(4'h8, 32'd2);
    run(30);
    // R10: polarity change while locked waits
    phase = "R10";
    wr(4'hC, 32'h51);
    run(25);
    // R9: unlock commits all together
    phase = "R9";
    wr(4'hC, 32'h11);
    run(30);

    // R11: alignment and low-power bits stored, no waveform effect
    phase = "R11";
    wr(4'hC, 32'h139);
    rd_chk(4'hC, 32'h139, "R11");
    run(25);

    // R4: disable parks counter, output idle high
    phase = "R4";
    wr(4'hC, 32'h10);
    run(10);
    rd_chk(4'h0, 32'h0, "R4");

    chk_on = 1'b0;
    run(3);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule